// File: doc/BRIEF.md
# Command Slot Issue Tracker

This block tracks which command slots of a single storage port are outstanding and feeds them one at a time to a command executor. Software sets bits in an issue bitmap and controls a start bit. While start is set, the tracker picks the lowest pending slot and reads that slot's 32-byte command header from memory. It splits the header into its fields and offers them to the executor. When the executor reports that the command has completed or failed, the tracker clears that slot's issue bit so that software can reuse the slot.

The header address is the command-list base with its low ten bits forced to zero, plus the slot number times 32. Only one command is in flight at any time. A running flag tells software whether the list engine is active. Software stops the engine by clearing start. The command in flight is allowed to finish, and the running flag drops only when it has.

The sequencer has five states. IDLE waits for work. FETCH drives the header read request. WAIT holds until the header data arrives. OFFER presents the decoded command to the executor. EXEC waits for the executor's completion or error pulse. The transitions are:
- IDLE to FETCH (dispatch) when start is set and at least one issue bit is set.
- FETCH to WAIT when the request is accepted.
- WAIT to OFFER when the response arrives.
- OFFER to EXEC when the executor accepts the command.
- EXEC to IDLE (retire) on a completion or error pulse.

Top module: `cmd_slot_tracker`

## Requirements
- R1: After reset the issue bitmap is 0, start is 0, running is 0, and neither the read request nor the command offer is valid.
- R2: A software write to the issue bitmap ORs the written bits into it. Written zeros have no effect, and software cannot clear a bit that is already set.
- R3: While start is 0 and no command is in flight, no header read is requested, and issue bits written by software are discarded (the bitmap reads 0 in the following cycle).
- R4: Among the set issue bits, the lowest-numbered slot is dispatched first. Only one header read is outstanding at a time. A stalled request holds its valid and its address until it is accepted.
- R5: The header read address is the list base with bits 9:0 forced to 0, plus the slot number shifted left by 5.
- R6: Header dword k is response bits 32k+31:32k. From dword 0, bits 4:0 give the FIS length, bits 15:12 give the multiplier port and bits 31:16 give the descriptor table length; all other dword-0 bits are ignored. Dword 1 gives the byte count. Dwords 3:2 give the 64-bit table pointer, with dword 3 as the upper half. The offer holds stable until it is accepted.
- R7: A completion pulse received while a command is executing clears only that slot's issue bit. Other bits are unchanged.
- R8: An error pulse received while a command is executing clears that slot's issue bit and clears start. The rest of the bitmap is then cleared and nothing further is dispatched.
- R9: Running equals start OR a command being in flight. If start is cleared while a command is in flight, that command still completes, no other slot is dispatched, and running drops in the same cycle the whole bitmap clears.
- R10: The capacity output reports the number of implemented slots minus one, as a 5-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_issue_we | input | 1 | Software write strobe for the issue bitmap |
| sw_issue_wdata | input | NUM_SLOTS | Bits to set in the issue bitmap |
| sw_start_we | input | 1 | Software write strobe for the start bit |
| sw_start_wdata | input | 1 | New start value |
| list_base | input | ADDR_W | Command-list base address |
| issue_map | output | NUM_SLOTS | Current issue bitmap |
| port_start | output | 1 | Current start bit |
| running | output | 1 | List engine active |
| slot_cap | output | 5 | Implemented slots minus one |
| rd_req_valid | output | 1 | Header read request valid |
| rd_req_ready | input | 1 | Header read request accepted |
| rd_req_addr | output | ADDR_W | Header byte address |
| rd_rsp_valid | input | 1 | Header data valid |
| rd_rsp_data | input | 256 | Whole 32-byte header |
| cmd_valid | output | 1 | Decoded command offered |
| cmd_ready | input | 1 | Executor accepts command |
| cmd_slot | output | SLOT_W | Slot of the offered command |
| cmd_prdtl | output | 16 | Descriptor table length |
| cmd_pmp | output | 4 | Multiplier port |
| cmd_cfl | output | 5 | Command FIS length |
| cmd_prdbc | output | 32 | Byte count field |
| cmd_ctba | output | 64 | Command table pointer |
| exec_done | input | 1 | Executing command completed |
| exec_fatal | input | 1 | Executing command failed |

## Verification
The assertions check several invariants on every cycle: the bitmap is empty whenever running is low; software never removes a set bit while the engine runs; a stalled request or offer holds steady; at most one fetch is in flight; and the offered slot is always still marked pending. Other behaviours depend on the stimulus and are shown only by the bench scenarios, which compare every cycle against a reference model. These are the lowest-first dispatch order (including a lower slot added while a higher slot is in flight), the exact header address for slots 0 and 31 with a misaligned base, the field split, the drain when start is stopped mid-command, and the error path that clears start and leaves the remaining slots undispatched.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int HDR_BITS        = 256;
    localparam int HDR_SHIFT       = 5;
    localparam int LIST_ALIGN_BITS = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_OFFER,
        ST_EXEC
    } seq_state_t;
endpackage

// File: rtl/cst_slot_pick.sv
module cst_slot_pick #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic [NUM_SLOTS-1:0] pending,
    output logic                 found,
    output logic [SLOT_W-1:0]    pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                pick  = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/cst_hdr_decode.sv
module cst_hdr_decode
    import cst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [HDR_BITS-1:0] hdr,
    output logic [15:0]         prdtl,
    output logic [3:0]          pmp,
    output logic [4:0]          cfl,
    output logic [31:0]         prdbc,
    output logic [63:0]         ctba
);
    localparam int KEEP_DW = 4;

    logic [31:0] dw_q [KEEP_DW];

    for (genvar k = 0; k < KEEP_DW; k++) begin : g_dw
        always_ff @(posedge clk) begin
            if (!rst_n)    dw_q[k] <= '0;
            else if (load) dw_q[k] <= hdr[32*k +: 32];
        end
    end

    assign cfl   = dw_q[0][4:0];
    assign pmp   = dw_q[0][15:12];
    assign prdtl = dw_q[0][31:16];
    assign prdbc = dw_q[1];
    assign ctba  = {dw_q[3], dw_q[2]};
endmodule

// File: rtl/cst_seq.sv
module cst_seq
    import cst_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_q,
    input  logic              have_work,
    input  logic [SLOT_W-1:0] pick,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic              cmd_ready,
    input  logic              exec_done,
    input  logic              exec_fatal,
    output logic              rd_req_valid,
    output logic              hdr_load,
    output logic              cmd_valid,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              retire,
    output logic              fatal_hit,
    output logic              busy,
    output logic              busy_next
);
    seq_state_t state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                         cur_slot <= '0;
        else if (state_q == ST_IDLE && start_q && have_work) cur_slot <= pick;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_q && have_work)     state_n = ST_FETCH;
            ST_FETCH: if (rd_req_ready)             state_n = ST_WAIT;
            ST_WAIT:  if (rd_rsp_valid)             state_n = ST_OFFER;
            ST_OFFER: if (cmd_ready)                state_n = ST_EXEC;
            ST_EXEC:  if (exec_done || exec_fatal)  state_n = ST_IDLE;
            default:                                state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req_valid = (state_q == ST_FETCH);
        hdr_load     = (state_q == ST_WAIT) && rd_rsp_valid;
        cmd_valid    = (state_q == ST_OFFER);
        retire       = (state_q == ST_EXEC) && (exec_done || exec_fatal);
        fatal_hit    = (state_q == ST_EXEC) && exec_fatal;
        busy         = (state_q != ST_IDLE);
        busy_next    = (state_n != ST_IDLE);
    end
endmodule

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker
    import cst_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 64,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_issue_we,
    input  logic [NUM_SLOTS-1:0] sw_issue_wdata,
    input  logic                 sw_start_we,
    input  logic                 sw_start_wdata,
    input  logic [ADDR_W-1:0]    list_base,
    output logic [NUM_SLOTS-1:0] issue_map,
    output logic                 port_start,
    output logic                 running,
    output logic [4:0]           slot_cap,
    output logic                 rd_req_valid,
    input  logic                 rd_req_ready,
    output logic [ADDR_W-1:0]    rd_req_addr,
    input  logic                 rd_rsp_valid,
    input  logic [HDR_BITS-1:0]  rd_rsp_data,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [SLOT_W-1:0]    cmd_slot,
    output logic [15:0]          cmd_prdtl,
    output logic [3:0]           cmd_pmp,
    output logic [4:0]           cmd_cfl,
    output logic [31:0]          cmd_prdbc,
    output logic [63:0]          cmd_ctba,
    input  logic                 exec_done,
    input  logic                 exec_fatal
);
    logic [NUM_SLOTS-1:0] issue_q, issue_n;
    logic                 start_q, start_n;
    logic                 have_work, hdr_load, retire, fatal_hit, busy, busy_next;
    logic [SLOT_W-1:0]    pick, cur_slot;
    logic [ADDR_W-1:0]    base_al;

    cst_slot_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
        .pending (issue_q),
        .found   (have_work),
        .pick    (pick)
    );

    cst_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_q      (start_q),
        .have_work    (have_work),
        .pick         (pick),
        .rd_req_ready (rd_req_ready),
        .rd_rsp_valid (rd_rsp_valid),
        .cmd_ready    (cmd_ready),
        .exec_done    (exec_done),
        .exec_fatal   (exec_fatal),
        .rd_req_valid (rd_req_valid),
        .hdr_load     (hdr_load),
        .cmd_valid    (cmd_valid),
        .cur_slot     (cur_slot),
        .retire       (retire),
        .fatal_hit    (fatal_hit),
        .busy         (busy),
        .busy_next    (busy_next)
    );

    cst_hdr_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hdr_load),
        .hdr   (rd_rsp_data),
        .prdtl (cmd_prdtl),
        .pmp   (cmd_pmp),
        .cfl   (cmd_cfl),
        .prdbc (cmd_prdbc),
        .ctba  (cmd_ctba)
    );

    always_comb begin
        start_n = start_q;
        if (sw_start_we) start_n = sw_start_wdata;
        if (fatal_hit)   start_n = 1'b0;

        issue_n = issue_q | (sw_issue_we ? sw_issue_wdata : '0);
        if (retire) issue_n = issue_n & ~(NUM_SLOTS'(1) << cur_slot);
        if (!start_n && !busy_next) issue_n = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q <= '0;
            start_q <= 1'b0;
        end else begin
            issue_q <= issue_n;
            start_q <= start_n;
        end
    end

    assign base_al     = {list_base[ADDR_W-1:LIST_ALIGN_BITS], {LIST_ALIGN_BITS{1'b0}}};
    assign rd_req_addr = base_al + (ADDR_W'(cur_slot) << HDR_SHIFT);
    assign cmd_slot    = cur_slot;
    assign issue_map   = issue_q;
    assign port_start  = start_q;
    assign running     = start_q | busy;
    assign slot_cap    = 5'(NUM_SLOTS - 1);
endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 64,
    parameter int SLOT_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] issue_map,
    input logic                 running,
    input logic                 port_start,
    input logic                 sw_start_we,
    input logic                 sw_start_wdata,
    input logic                 rd_req_valid,
    input logic                 rd_req_ready,
    input logic [ADDR_W-1:0]    rd_req_addr,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [SLOT_W-1:0]    cmd_slot,
    input logic                 exec_done,
    input logic                 exec_fatal
);
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (issue_map == '0)); // R9

    AST_STOPPED_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rd_req_valid); // R3

    AST_SW_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (running && port_start && !exec_done && !exec_fatal && !(sw_start_we && !sw_start_wdata))
        |=> ((issue_map & $past(issue_map)) == $past(issue_map))); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R4

    AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && rd_req_ready) |=> !rd_req_valid); // R4

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_slot))); // R6

    AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> issue_map[cmd_slot]); // R7
endmodule

bind cmd_slot_tracker cst_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .SLOT_W    (SLOT_W)
) u_cst_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_map      (issue_map),
    .running        (running),
    .port_start     (port_start),
    .sw_start_we    (sw_start_we),
    .sw_start_wdata (sw_start_wdata),
    .rd_req_valid   (rd_req_valid),
    .rd_req_ready   (rd_req_ready),
    .rd_req_addr    (rd_req_addr),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_slot       (cmd_slot),
    .exec_done      (exec_done),
    .exec_fatal     (exec_fatal)
);

// File: tb/tb_cmd_slot_tracker.sv
`timescale 1ns/1ps
module tb_cmd_slot_tracker;
    localparam int N = 32;
    localparam int AW = 64;
    localparam int EXEC_LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          sw_issue_we = 1'b0;
    logic [N-1:0]  sw_issue_wdata = '0;
    logic          sw_start_we = 1'b0;
    logic          sw_start_wdata = 1'b0;
    logic [AW-1:0] list_base = 64'h0000_1234_5678_9ABC;
    logic [N-1:0]  issue_map;
    logic          port_start, running, rd_req_valid, cmd_valid;
    logic [4:0]    slot_cap;
    logic          mem_ready = 1'b1;
    logic          ex_ready = 1'b1;
    logic [AW-1:0] rd_req_addr;
    logic          rsp_pend = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [255:0]  rd_rsp_data;
    logic [4:0]    cmd_slot;
    logic [15:0]   cmd_prdtl;
    logic [3:0]    cmd_pmp;
    logic [4:0]    cmd_cfl;
    logic [31:0]   cmd_prdbc;
    logic [63:0]   cmd_ctba;
    logic          exec_done, exec_fatal;
    int            exec_cnt = 0;
    int            exec_slot = 0;
    int            fatal_slot = -1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int log_q[$];

    function automatic logic [255:0] hdr_for(int s);
        logic [255:0] h;
        h = {8{32'hDEAD_0000 + 32'(s)}};
        h[31:0]   = {16'(s * 7 + 3), 4'(s), 7'h55, 5'(s + 2)};
        h[63:32]  = 32'hB000_0000 + 32'(s);
        h[95:64]  = 32'h0010_0080 + 32'(s * 128);
        h[127:96] = 32'h0000_00A0 + 32'(s);
        return h;
    endfunction

    assign rd_rsp_data = hdr_for(int'((rsp_addr >> 5) & 64'd31));
    assign exec_done   = (exec_cnt == 1) && (exec_slot != fatal_slot);
    assign exec_fatal  = (exec_cnt == 1) && (exec_slot == fatal_slot);

    cmd_slot_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .sw_issue_we(sw_issue_we), .sw_issue_wdata(sw_issue_wdata),
        .sw_start_we(sw_start_we), .sw_start_wdata(sw_start_wdata),
        .list_base(list_base),
        .issue_map(issue_map), .port_start(port_start), .running(running), .slot_cap(slot_cap),
        .rd_req_valid(rd_req_valid), .rd_req_ready(mem_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rsp_pend), .rd_rsp_data(rd_rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(ex_ready), .cmd_slot(cmd_slot),
        .cmd_prdtl(cmd_prdtl), .cmd_pmp(cmd_pmp), .cmd_cfl(cmd_cfl),
        .cmd_prdbc(cmd_prdbc), .cmd_ctba(cmd_ctba),
        .exec_done(exec_done), .exec_fatal(exec_fatal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // memory and executor stand-ins
    always @(posedge clk) begin
        rsp_pend <= rd_req_valid && mem_ready;
        if (rd_req_valid && mem_ready) rsp_addr <= rd_req_addr;
        if (cmd_valid && ex_ready) begin
            exec_cnt  <= EXEC_LAT;
            exec_slot <= int'(cmd_slot);
            log_q.push_back(int'(cmd_slot));
        end else if (exec_cnt > 0) begin
            exec_cnt <= exec_cnt - 1;
        end
    end

    // reference model
    logic [N-1:0] m_issue = '0;
    bit m_start = 1'b0;
    bit m_busy = 1'b0;
    int m_cur = 0;

    always @(posedge clk) begin
        logic [N-1:0] ni;
        bit ns, nb, fin;
        int low;
        if (!rst_n) begin
            m_issue <= '0; m_start <= 1'b0; m_busy <= 1'b0; m_cur <= 0;
        end else begin
            if (rd_req_valid && mem_ready)
                check(rd_req_addr == ({list_base[63:10], 10'b0} + 64'(m_cur * 32)),
                      "R5", rd_req_addr, {list_base[63:10], 10'b0} + 64'(m_cur * 32));
            if (cmd_valid && ex_ready) begin
                logic [255:0] h;
                h = hdr_for(m_cur);
                check(int'(cmd_slot) == m_cur, "R4", 64'(cmd_slot), 64'(m_cur));
                check(cmd_cfl == h[4:0] && cmd_pmp == h[15:12] && cmd_prdtl == h[31:16],
                      "R6", {cmd_prdtl, cmd_pmp, cmd_cfl}, {h[31:16], h[15:12], h[4:0]});
                check(cmd_prdbc == h[63:32] && cmd_ctba == h[127:64], "R6", cmd_ctba, h[127:64]);
            end
            fin = m_busy && (exec_done || exec_fatal);
            low = -1;
            for (int i = N - 1; i >= 0; i--) if (m_issue[i]) low = i;
            ni = m_issue | (sw_issue_we ? sw_issue_wdata : '0);
            if (fin) ni[m_cur] = 1'b0;
            ns = sw_start_we ? sw_start_wdata : m_start;
            if (m_busy && exec_fatal) ns = 1'b0;
            nb = m_busy;
            if (fin) nb = 1'b0;
            if (!m_busy && m_start && low >= 0) begin
                nb = 1'b1;
                m_cur <= low;
            end
            if (!ns && !nb) ni = '0;
            m_issue <= ni; m_start <= ns; m_busy <= nb;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(issue_map == m_issue, "R7", 64'(issue_map), 64'(m_issue));
            check(running == (m_start || m_busy), "R9", 64'(running), 64'(m_start || m_busy));
            check(port_start == m_start, "R8", 64'(port_start), 64'(m_start));
            if (!m_busy) check(!rd_req_valid && !cmd_valid, "R3", 64'(rd_req_valid), 64'd0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_issue(input logic [N-1:0] d);
        @(negedge clk); #1;
        sw_issue_we = 1'b1; sw_issue_wdata = d;
        @(negedge clk); #1;
        sw_issue_we = 1'b0; sw_issue_wdata = '0;
    endtask

    task automatic wr_start(input bit v);
        @(negedge clk); #1;
        sw_start_we = 1'b1; sw_start_wdata = v;
        @(negedge clk); #1;
        sw_start_we = 1'b0;
    endtask

    task automatic wait_quiet();
        int lim = 0;
        while ((running && port_start === 1'b0) || (port_start && issue_map != '0) || (!port_start && running)) begin
            @(negedge clk);
            lim++;
            if (lim > 2000) begin
                check(1'b0, "R9", 64'(issue_map), 64'd0);
                break;
            end
        end
        #1;
    endtask

    task automatic wait_offer();
        int lim = 0;
        while (!cmd_valid && lim < 200) begin @(negedge clk); lim++; end
        #1;
    endtask

    task automatic check_log(input string req, input int exp[$]);
        bit ok;
        ok = (log_q.size() == exp.size());
        if (ok) foreach (exp[i]) if (log_q[i] != exp[i]) ok = 1'b0;
        check(ok, req, 64'(log_q.size() > 0 ? log_q[0] : -1), 64'(exp.size() > 0 ? exp[0] : -1));
        log_q.delete();
    endtask

    initial begin
        logic [N-1:0] snap;
        tick(3);
        // R1 reset state
        check(issue_map == '0 && !port_start, "R1", 64'(issue_map), 64'd0);
        check(!running && !rd_req_valid && !cmd_valid, "R1", 64'(running), 64'd0);
        check(slot_cap == 5'd31, "R10", 64'(slot_cap), 64'd31);
        rst_n = 1'b1;
        tick(2);

        // R3 writes while stopped are discarded
        wr_issue(32'hFF);
        check(issue_map == '0, "R3", 64'(issue_map), 64'd0);
        tick(4);
        check(!rd_req_valid && !running, "R3", 64'(rd_req_valid), 64'd0);

        // R4 lowest first, with a lower slot added mid-flight; R2 writing zeros
        wr_start(1'b1);
        wr_issue(32'h0000_00A4);
        wait_offer();
        snap = issue_map;
        wr_issue(32'h0);
        check(issue_map == snap, "R2", 64'(issue_map), 64'(snap));
        wr_issue(32'h1);
        check(issue_map == (snap | 32'h1), "R2", 64'(issue_map), 64'(snap | 32'h1));
        wait_quiet();
        check_log("R4", '{2, 0, 5, 7});
        check(running && issue_map == '0, "R7", 64'(issue_map), 64'd0);

        // R4 stalled request and R6 stalled offer
        mem_ready = 1'b0;
        wr_issue(32'h200);
        tick(5);
        check(rd_req_valid == 1'b1, "R4", 64'(rd_req_valid), 64'd1);
        ex_ready = 1'b0;
        mem_ready = 1'b1;
        wait_offer();
        tick(3);
        check(cmd_valid && cmd_slot == 5'd9, "R6", 64'(cmd_slot), 64'd9);
        ex_ready = 1'b1;
        wait_quiet();
        check_log("R4", '{9});

        // R5 top slot with misaligned base
        list_base = 64'h0000_0000_ABCD_E3FF;
        wr_issue(32'h8000_0000);
        wait_quiet();
        check_log("R5", '{31});

        // R9 stop while a command is in flight
        wr_issue(32'h18);
        wait_offer();
        wr_start(1'b0);
        wait_quiet();
        check(!running && issue_map == '0, "R9", 64'(issue_map), 64'd0);
        check_log("R9", '{3});

        // R8 error pulse clears start and the remaining slot
        fatal_slot = 1;
        wr_start(1'b1);
        wr_issue(32'h42);
        wait_quiet();
        check(!port_start && issue_map == '0, "R8", 64'(port_start), 64'd0);
        check_log("R8", '{1});
        fatal_slot = -1;
        wr_start(1'b1);
        wr_issue(32'h40);
        wait_quiet();
        check_log("R8", '{6});

        tick(3);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog R9 actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule